// File: doc/BRIEF.md
# Packet Interrupt Delay Timers

This block decides when a "packets done" interrupt cause should be raised for one traffic direction of a network controller. It holds two timers. The first is a per-packet timer that is reloaded from its full delay on every qualifying packet completion. The second is an absolute timer that is loaded by the first qualifying completion and is never pushed out by later completions. Both count down in whole periods of an external interrupt tick strobe. Whichever timer runs out first emits a one-cycle cause pulse and stops both.

A parameter selects the direction. In the receive variant, every completion qualifies. The absolute timer arms whenever its own delay is nonzero. If both delays are zero, the cause is raised straight away. In the transmit variant, only completions that carry the delay-request flag count. The absolute timer arms only when both delays are nonzero, and there is no immediate fallback.

When the interrupt logic actually posts an interrupt, it drives the cancel input. Any pending timer is then dropped and the cause is reported at once. All pins are plain control and status signals. No data flows through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `pkt_irq_delay`

## Requirements
- R1: During and right after reset, `cause_o` is 0 and `armed_o` is 2'b00.
- R2: With a per-packet delay D > 0, a qualifying completion sets `armed_o[0]`. `cause_o` is 1 in the cycle after the D-th `tick_i` cycle that follows the completion, and not earlier.
- R3: A qualifying completion while the per-packet timer is running reloads it with the full delay, which moves its expiry later.
- R4: The absolute timer (`armed_o[1]`) loads only when it is not running. Later completions do not extend it, and it stays armed until a tick expires it or a cancel arrives.
- R5: In the receive variant (`IS_TX`=0), the absolute timer arms whenever its delay is nonzero, even when the per-packet delay is zero.
- R6: In the transmit variant (`IS_TX`=1), completions with `done_ide_i`=0 are ignored. The absolute timer arms only when both delays are nonzero.
- R7: In the receive variant, a completion with both delays zero gives `cause_o`=1 on the next cycle and arms nothing. In the transmit variant, the same stimulus raises nothing.
- R8: When either timer expires, `cause_o` is high for exactly that one cycle (absent new triggers), and both bits of `armed_o` are 0 afterwards.
- R9: `cancel_i` while any timer is armed clears both timers and gives `cause_o`=1 on the next cycle. `cancel_i` with nothing armed raises no cause.
- R10: A delay value of zero disables its timer: the matching `armed_o` bit stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_vld_i | input | 1 | One-cycle packet completion pulse |
| done_ide_i | input | 1 | Completion requests a delayed interrupt (transmit variant only) |
| pkt_dly_i | input | DLY_W | Per-packet delay in ticks, 0 disables |
| abs_dly_i | input | DLY_W | Absolute delay in ticks, 0 disables |
| tick_i | input | 1 | Interrupt clock strobe, one cycle per period |
| cancel_i | input | 1 | An interrupt was posted; drop pending timers |
| cause_o | output | 1 | One-cycle cause-raise pulse |
| armed_o | output | 2 | Bit 0 per-packet timer running, bit 1 absolute timer running |

## Verification
The bench drives both variants with the same stimulus and targets several corner cases:
- A per-packet timer that is not reloaded on a second completion fires too early.
- An absolute timer that is reloaded on later completions fires late.
- Swapping the receive and transmit arming rules arms the absolute timer in the wrong variant, or drops the immediate fallback.
- A cancel that does not report the pending cause leaves `cause_o` low.
- An expiry that stops only one timer leaves the other bit of `armed_o` set.

Random completions, ticks and cancels with small delays then stress same-cycle collisions between loads, expiries and cancels.

// File: rtl/pid_pkg.sv
package pid_pkg;
  typedef enum logic [0:0] {
    TMR_PKT = 1'b0,
    TMR_ABS = 1'b1
  } tmr_idx_e;

  localparam int unsigned NUM_TMR = 2;

  typedef struct packed {
    logic load_pkt;
    logic load_abs;
    logic fire_now;
  } arm_dec_t;
endpackage

// File: rtl/pid_timer.sv
module pid_timer #(
  parameter int unsigned W       = 16,
  parameter bit          RESTART = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         clear_i,
  input  logic         tick_i,
  output logic         run_o,
  output logic         hit_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic         run_q;
  logic         load_ok;

  generate
    if (RESTART) begin : g_restart
      assign load_ok = load_i;
    end else begin : g_once
      // a running absolute timer ignores loads unless it is being cleared now
      assign load_ok = load_i && (!run_q || clear_i);
    end
  endgenerate

  assign hit_o = run_q && tick_i && (cnt_q == ONE);
  assign run_o = run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (clear_i) begin
        run_q <= 1'b0;
      end else if (tick_i && run_q) begin
        if (cnt_q == ONE) run_q <= 1'b0;
        else              cnt_q <= cnt_q - ONE;
      end
      if (load_ok) begin
        run_q <= 1'b1;
        cnt_q <= load_val_i;
      end
    end
  end
endmodule

// File: rtl/pid_arm_ctl.sv
module pid_arm_ctl
  import pid_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter bit          IS_TX = 1'b0
) (
  input  logic         done_vld_i,
  input  logic         done_ide_i,
  input  logic [W-1:0] pkt_dly_i,
  input  logic [W-1:0] abs_dly_i,
  output arm_dec_t     dec_o
);
  logic pkt_on, abs_on;
  assign pkt_on = (pkt_dly_i != '0);
  assign abs_on = (abs_dly_i != '0);

  generate
    if (IS_TX) begin : g_tx
      logic qual;
      assign qual           = done_vld_i && done_ide_i;
      assign dec_o.load_pkt = qual && pkt_on;
      assign dec_o.load_abs = qual && pkt_on && abs_on;
      assign dec_o.fire_now = 1'b0;
    end else begin : g_rx
      logic unused_ide;
      assign unused_ide     = done_ide_i;
      assign dec_o.load_pkt = done_vld_i && pkt_on;
      assign dec_o.load_abs = done_vld_i && abs_on;
      assign dec_o.fire_now = done_vld_i && !pkt_on && !abs_on;
    end
  endgenerate
endmodule

// File: rtl/pid_cause.sv
module pid_cause (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic cancel_i,
  input  logic any_run_i,
  input  logic fire_now_i,
  output logic cause_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) cause_o <= 1'b0;
    else        cause_o <= expire_i || (cancel_i && any_run_i) || fire_now_i;
  end
endmodule

// File: rtl/pkt_irq_delay.sv
module pkt_irq_delay
  import pid_pkg::*;
#(
  parameter int unsigned DLY_W = 16,
  parameter bit          IS_TX = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_vld_i,
  input  logic             done_ide_i,
  input  logic [DLY_W-1:0] pkt_dly_i,
  input  logic [DLY_W-1:0] abs_dly_i,
  input  logic             tick_i,
  input  logic             cancel_i,
  output logic             cause_o,
  output logic [1:0]       armed_o
);
  arm_dec_t         dec;
  logic [NUM_TMR-1:0] run, hit, load;
  logic [DLY_W-1:0] dly [NUM_TMR];
  logic             expire, clr_all;

  pid_arm_ctl #(.W(DLY_W), .IS_TX(IS_TX)) u_arm (
    .done_vld_i (done_vld_i),
    .done_ide_i (done_ide_i),
    .pkt_dly_i  (pkt_dly_i),
    .abs_dly_i  (abs_dly_i),
    .dec_o      (dec)
  );

  assign load[TMR_PKT] = dec.load_pkt;
  assign load[TMR_ABS] = dec.load_abs;
  assign dly[TMR_PKT]  = pkt_dly_i;
  assign dly[TMR_ABS]  = abs_dly_i;

  assign expire  = |hit;
  assign clr_all = expire || cancel_i;

  generate
    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
      pid_timer #(.W(DLY_W), .RESTART(g == int'(TMR_PKT))) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load[g]),
        .load_val_i (dly[g]),
        .clear_i    (clr_all),
        .tick_i     (tick_i),
        .run_o      (run[g]),
        .hit_o      (hit[g])
      );
    end
  endgenerate

  pid_cause u_cause (
    .clk        (clk),
    .rst_n      (rst_n),
    .expire_i   (expire),
    .cancel_i   (cancel_i),
    .any_run_i  (|run),
    .fire_now_i (dec.fire_now),
    .cause_o    (cause_o)
  );

  assign armed_o = {run[TMR_ABS], run[TMR_PKT]};
endmodule

// File: rtl/pkt_irq_delay_chk.sv
module pkt_irq_delay_chk #(
  parameter int unsigned DLY_W = 16,
  parameter bit          IS_TX = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done_vld_i,
  input logic             done_ide_i,
  input logic [DLY_W-1:0] pkt_dly_i,
  input logic [DLY_W-1:0] abs_dly_i,
  input logic             tick_i,
  input logic             cancel_i,
  input logic             cause_o,
  input logic [1:0]       armed_o
);
  // R9
  cancel_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel_i && (armed_o != 2'b00) && !done_vld_i) |=> (cause_o && armed_o == 2'b00));

  // R7
  rx_immediate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!IS_TX && done_vld_i && pkt_dly_i == '0 && abs_dly_i == '0) |=> cause_o);

  // R10
  zero_pkt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_dly_i == '0 && !armed_o[0]) |=> !armed_o[0]);

  // R6
  tx_no_ide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_TX && !(done_vld_i && done_ide_i) && armed_o == 2'b00) |=> armed_o == 2'b00);

  // R4
  abs_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_o[1] && !tick_i && !cancel_i) |=> armed_o[1]);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!cause_o && armed_o == 2'b00));
endmodule

bind pkt_irq_delay pkt_irq_delay_chk #(.DLY_W(DLY_W), .IS_TX(IS_TX)) u_chk (.*);

// File: tb/pkt_irq_delay_test.sv
module pkt_irq_delay_test;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0, ide = 1'b0, tick = 1'b0, cancel = 1'b0;
  logic [W-1:0] pd = '0, ad = '0;
  logic cause_rx, cause_tx;
  logic [1:0] armed_rx, armed_tx;

  int checks = 0;
  int errors = 0;

  // model state, index 0 receive, 1 transmit
  logic m_prun [2];
  logic m_arun [2];
  int   m_pcnt [2];
  int   m_acnt [2];
  logic m_cause [2];

  always #10 clk = ~clk;

  pkt_irq_delay #(.DLY_W(W), .IS_TX(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .done_vld_i(vld), .done_ide_i(ide),
    .pkt_dly_i(pd), .abs_dly_i(ad), .tick_i(tick), .cancel_i(cancel),
    .cause_o(cause_rx), .armed_o(armed_rx));

  pkt_irq_delay #(.DLY_W(W), .IS_TX(1'b1)) uut_tx (
    .clk(clk), .rst_n(rst_n), .done_vld_i(vld), .done_ide_i(ide),
    .pkt_dly_i(pd), .abs_dly_i(ad), .tick_i(tick), .cancel_i(cancel),
    .cause_o(cause_tx), .armed_o(armed_tx));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic tx_of(input int v);
    return v == 1;
  endfunction

  // advance the reference model for one clock edge with the current inputs
  task automatic model_step();
    for (int v = 0; v < 2; v++) begin
      logic qual, hit, clr, anyrun;
      qual   = vld && (tx_of(v) ? ide : 1'b1);
      hit    = tick && ((m_prun[v] && m_pcnt[v] == 1) || (m_arun[v] && m_acnt[v] == 1));
      anyrun = m_prun[v] || m_arun[v];
      clr    = hit || cancel;
      m_cause[v] = hit || (cancel && anyrun) ||
                   (!tx_of(v) && qual && pd == 0 && ad == 0);
      if (clr) begin
        m_prun[v] = 1'b0;
        m_arun[v] = 1'b0;
      end else if (tick) begin
        if (m_prun[v]) m_pcnt[v]--;
        if (m_arun[v]) m_acnt[v]--;
      end
      if (qual && pd != 0) begin
        m_prun[v] = 1'b1;
        m_pcnt[v] = int'(pd);
      end
      if (qual && ad != 0 && (!tx_of(v) || pd != 0) && !m_arun[v]) begin
        m_arun[v] = 1'b1;
        m_acnt[v] = int'(ad);
      end
    end
  endtask

  task automatic step(input logic v, input logic i, input logic t, input logic c);
    vld = v; ide = i; tick = t; cancel = c;
    model_step();
    @(negedge clk);
    chk("R8 rx cause model", int'(cause_rx), int'(m_cause[0]));
    chk("R2 rx armed model", int'(armed_rx), int'({m_arun[0], m_prun[0]}));
    chk("R8 tx cause model", int'(cause_tx), int'(m_cause[1]));
    chk("R6 tx armed model", int'(armed_tx), int'({m_arun[1], m_prun[1]}));
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4321));
    for (int v = 0; v < 2; v++) begin
      m_prun[v] = 0; m_arun[v] = 0; m_pcnt[v] = 0; m_acnt[v] = 0; m_cause[v] = 0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cause", int'(cause_rx), 0);
    chk("R1 armed", int'(armed_rx), 0);
    rst_n = 1'b1;
    step(0, 0, 0, 0);
    chk("R1 after release", int'(armed_tx), 0);

    // R2 per-packet expiry on third tick
    pd = 3; ad = 0;
    step(1, 1, 0, 0);
    chk("R2 armed", int'(armed_rx), 1);
    step(0, 0, 1, 0); step(0, 0, 1, 0);
    chk("R2 early", int'(cause_rx), 0);
    step(0, 0, 1, 0);
    chk("R2 fire", int'(cause_rx), 1);
    chk("R8 stop", int'(armed_rx), 0);
    step(0, 0, 0, 0);
    chk("R8 single", int'(cause_rx), 0);

    // R3 restart
    step(1, 1, 0, 0);
    step(0, 0, 1, 0); step(0, 0, 1, 0);
    step(1, 1, 0, 0);
    step(0, 0, 1, 0); step(0, 0, 1, 0);
    chk("R3 extended", int'(cause_rx), 0);
    step(0, 0, 1, 0);
    chk("R3 fire", int'(cause_rx), 1);

    // R4 absolute not extended
    pd = 5; ad = 3;
    step(1, 1, 0, 0); step(0, 0, 1, 0);
    step(1, 1, 0, 0); step(0, 0, 1, 0);
    step(1, 1, 0, 0);
    chk("R4 still armed", int'(armed_rx), 3);
    step(0, 0, 1, 0);
    chk("R4 fire", int'(cause_rx), 1);
    chk("R4 stop", int'(armed_rx), 0);

    // R5 / R6 abs with zero per-packet delay
    pd = 0; ad = 2;
    step(1, 1, 0, 0);
    chk("R5 rx abs", int'(armed_rx), 2);
    chk("R6 tx abs off", int'(armed_tx), 0);
    step(0, 0, 1, 0); step(0, 0, 1, 0);
    chk("R5 fire", int'(cause_rx), 1);

    // R6 ide flag, then R9 cancel
    pd = 2; ad = 4;
    step(1, 0, 0, 0);
    chk("R6 ide ignored", int'(armed_tx), 0);
    chk("R6 rx armed", int'(armed_rx), 3);
    step(1, 1, 0, 0);
    chk("R6 tx both", int'(armed_tx), 3);
    step(0, 0, 0, 1);
    chk("R9 rx cause", int'(cause_rx), 1);
    chk("R9 rx clear", int'(armed_rx), 0);
    chk("R9 tx cause", int'(cause_tx), 1);
    step(0, 0, 0, 1);
    chk("R9 idle cancel", int'(cause_rx), 0);

    // R7 immediate fallback
    pd = 0; ad = 0;
    step(1, 1, 0, 0);
    chk("R7 rx now", int'(cause_rx), 1);
    chk("R7 rx none armed", int'(armed_rx), 0);
    chk("R7 tx silent", int'(cause_tx), 0);

    // R10 zero abs delay
    pd = 4; ad = 0;
    step(1, 1, 0, 0);
    chk("R10 abs off", int'(armed_rx), 1);
    step(0, 0, 0, 1);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      if (n % 200 == 0) begin
        pd = W'($urandom % 5);
        ad = W'($urandom % 7);
      end
      step(($urandom % 6) == 0, ($urandom % 3) != 0,
           ($urandom % 3) == 0, ($urandom % 40) == 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule